// File: doc/BRIEF.md
# Narrow-Port Beat Accumulator

This block links a 64-bit host data path to an external memory whose data port is 64, 32, 16 or 8 bits wide. The memory timing logic sends a strobe each time the memory has either latched one narrow slice of a write or presented one valid slice of a read. The block counts these strobes. When the slices that make up one host beat are complete, it returns a single-cycle acknowledge to the host. The host beat is a full double word or a smaller transfer.

On reads, each narrow slice arrives on the most significant lines of the external bus. The block places the slice into its position in a 64-bit word, working from the most significant end. On writes, the block moves the matching slice of the host word onto those same upper lines. Slices always go most significant first. Timing generation and address stepping belong to other logic.

A start pulse captures the port size, transfer size and direction for the beats that follow. A burst keeps strobing after that, and every completed beat receives its own acknowledge.

Top module: `nba_beat_accum`

## Requirements
- R1: After reset, `ack`, `host_rdata` and `mem_wdata` are all zero, and strobes that arrive before the first `start` are ignored.
- R2: With `port_sz`=0 (64-bit port), every beat takes exactly one strobe for any `xfer_sz` (0 byte, 1 half word, 2 word, 3 double word). The strobe count never reaches the required number while it is held.
- R3: With `port_sz`=1 (32-bit port), a double word takes 2 strobes and a word, half word or byte takes 1.
- R4: With `port_sz`=2 (16-bit port), a double word takes 4 strobes, a word takes 2, and a half word or byte takes 1.
- R5: With `port_sz`=3 (8-bit port), a double word takes 8 strobes, a word 4, a half word 2 and a byte 1.
- R6: `ack` is high for exactly the one cycle that follows the clock edge sampling the final strobe of a beat. The count then clears, so strobes held high continuously on a 64-bit port produce one `ack` per cycle.
- R7: On a read, the slice sampled at the k-th strobe of a beat (k from 0) is taken from the top W lines of `mem_rdata` (W = port width) and written to `host_rdata[63-k*W : 64-(k+1)*W]`. The first strobe zeroes every bit outside its own slice. The completed word is visible in the `ack` cycle and is held until the next read strobe.
- R8: During a write beat with slice index k, the top W lines of `mem_wdata` carry `host_wdata[63-k*W : 64-(k+1)*W]` and the lower lines are zero. When no write is active, `mem_wdata` is zero.
- R9: `start` captures `port_sz`, `xfer_sz` and `is_read` and discards any partly counted beat. A strobe in the same cycle as `start` is not counted.
- R10: Write beats never change `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transfer and captures its configuration |
| port_sz | input | 2 | Memory port width: 0=64, 1=32, 2=16, 3=8 bits |
| xfer_sz | input | 2 | Transfer size: 0 byte, 1 half word, 2 word, 3 double word |
| is_read | input | 1 | 1 = read, 0 = write |
| pstrobe | input | 1 | Partial slice transferred this cycle |
| mem_rdata | input | 64 | External read bus; narrow data on the top lines |
| host_wdata | input | 64 | Host write word |
| ack | output | 1 | Host beat complete, one cycle |
| host_rdata | output | 64 | Assembled read word |
| mem_wdata | output | 64 | Write slice placed on the top lines |

## Verification
An error in the captured size or in the strobe count shows up as an `ack` one or more cycles early or late, or as a missing `ack`, during the first beat after `start`. An error in the slice index shows up as bytes in the wrong place in `host_rdata` in the `ack` cycle. The same error puts the wrong host bytes on `mem_wdata` in the very cycle of the faulty strobe. The bench therefore checks `ack` after every strobe, checks the write lanes before each strobe, and checks the read word in each `ack` cycle.

// File: rtl/nba_pkg.sv
package nba_pkg;
    localparam int DATA_W  = 64;
    localparam int NBYTES  = DATA_W / 8;
    localparam int LOGB    = $clog2(NBYTES);
    localparam int CNT_W   = $clog2(NBYTES);
    localparam int SZ_W    = $clog2(LOGB + 1);

    typedef enum logic [SZ_W-1:0] {
        PORT_FULL    = 2'd0,
        PORT_HALF    = 2'd1,
        PORT_QUARTER = 2'd2,
        PORT_EIGHTH  = 2'd3
    } port_e;

    typedef enum logic [SZ_W-1:0] {
        XF_BYTE  = 2'd0,
        XF_HALF  = 2'd1,
        XF_WORD  = 2'd2,
        XF_DWORD = 2'd3
    } xfer_e;

    typedef struct packed {
        logic             active;
        port_e            port;
        xfer_e            xfer;
        logic             is_read;
        logic [CNT_W-1:0] cnt;
        logic             ack;
    } ctl_state_t;
endpackage

// File: rtl/nba_strobe_lut.sv
module nba_strobe_lut
    import nba_pkg::*;
#(
    parameter int LOG_BYTES = LOGB,
    parameter int CW        = CNT_W
) (
    input  logic [SZ_W-1:0] port_sz,
    input  logic [SZ_W-1:0] xfer_sz,
    output logic [CW:0]     need
);
    // strobes = transfer bytes / port bytes, never below one
    always_comb begin
        int e;
        e = int'(xfer_sz) + int'(port_sz) - LOG_BYTES;
        if (e < 0) e = 0;
        need = {{CW{1'b0}}, 1'b1} << e;
    end
endmodule

// File: rtl/nba_lane_map.sv
module nba_lane_map
    import nba_pkg::*;
#(
    parameter int LOG_BYTES = LOGB
) (
    input  logic [SZ_W-1:0]      port_sz,
    output logic [SZ_W-1:0]      lane_log,
    output logic [LOG_BYTES-1:0] lane_mask
);
    // log2 of the port width in bytes, and a mask selecting a byte lane within it
    assign lane_log  = SZ_W'(LOG_BYTES) - port_sz;
    assign lane_mask = LOG_BYTES'((1 << lane_log) - 1);
endmodule

// File: rtl/nba_read_pack.sv
module nba_read_pack
    import nba_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SZ_W-1:0] lane_log,
    input  logic [LOGB-1:0] lane_mask,
    input  logic [CW-1:0]   slice_idx,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   rdata
);
    localparam int NB = DW / 8;

    typedef struct packed {
        logic [DW-1:0] word;
    } pack_state_t;

    pack_state_t st_q, st_d;
    logic [7:0]  lane_b [NB];
    logic [7:0]  src_b  [NB];
    logic [NB-1:0] hit;

    // byte 0 is the most significant byte
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign lane_b[b] = mem_rdata[DW-1-8*b -: 8];
        assign hit[b]    = (CW'(b >> lane_log) == slice_idx);
        assign src_b[b]  = lane_b[LOGB'(b) & lane_mask];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (hit[b])
                    st_d.word[DW-1-8*b -: 8] = src_b[b];
                else if (slice_idx == '0)
                    st_d.word[DW-1-8*b -: 8] = 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.word;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rdata)); // R7
endmodule

// File: rtl/nba_write_steer.sv
module nba_write_steer
    import nba_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic            en,
    input  logic [SZ_W-1:0] lane_log,
    input  logic [CW-1:0]   slice_idx,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   mem_wdata
);
    localparam int NB = DW / 8;

    logic [7:0]      host_b [NB];
    logic [LOGB-1:0] base;

    assign base = LOGB'(slice_idx) << lane_log;

    for (genvar j = 0; j < NB; j++) begin : g_lane
        assign host_b[j] = host_wdata[DW-1-8*j -: 8];
        // output lane j is live only when it lies within the port width
        assign mem_wdata[DW-1-8*j -: 8] =
            (en && ((j >> lane_log) == 0)) ? host_b[base | LOGB'(j)] : 8'h00;
    end
endmodule

// File: rtl/nba_beat_accum.sv
module nba_beat_accum
    import nba_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  port_sz,
    input  logic [1:0]  xfer_sz,
    input  logic        is_read,
    input  logic        pstrobe,
    input  logic [63:0] mem_rdata,
    input  logic [63:0] host_wdata,
    output logic        ack,
    output logic [63:0] host_rdata,
    output logic [63:0] mem_wdata
);
    ctl_state_t      st_q, st_d;
    logic [CNT_W:0]  need;
    logic [SZ_W-1:0] lane_log;
    logic [LOGB-1:0] lane_mask;
    logic            strobe_ok;
    logic            last_slice;

    nba_strobe_lut u_lut (
        .port_sz (st_q.port),
        .xfer_sz (st_q.xfer),
        .need    (need)
    );

    nba_lane_map u_map (
        .port_sz   (st_q.port),
        .lane_log  (lane_log),
        .lane_mask (lane_mask)
    );

    assign strobe_ok  = st_q.active && pstrobe && !start;
    assign last_slice = ({1'b0, st_q.cnt} == need - 1'b1);

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (start) begin
            st_d.active  = 1'b1;
            st_d.port    = port_e'(port_sz);
            st_d.xfer    = xfer_e'(xfer_sz);
            st_d.is_read = is_read;
            st_d.cnt     = '0;
        end else if (strobe_ok) begin
            if (last_slice) begin
                st_d.cnt = '0;
                st_d.ack = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nba_read_pack u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (strobe_ok && st_q.is_read),
        .lane_log  (lane_log),
        .lane_mask (lane_mask),
        .slice_idx (st_q.cnt),
        .mem_rdata (mem_rdata),
        .rdata     (host_rdata)
    );

    nba_write_steer u_wr (
        .en         (st_q.active && !st_q.is_read),
        .lane_log   (lane_log),
        .slice_idx  (st_q.cnt),
        .host_wdata (host_wdata),
        .mem_wdata  (mem_wdata)
    );

    assign ack = st_q.ack;

    AST_ACK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(pstrobe && !start)); // R6
    AST_NO_ACK_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(st_q.active)); // R9
    AST_CNT_BELOW_NEED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> ({1'b0, st_q.cnt} < need)); // R2
    AST_WSLICE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active || st_q.is_read) |-> (mem_wdata == '0)); // R8
endmodule

// File: tb/tb_nba_beat_accum.sv
module tb_nba_beat_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  port_sz = '0;
    logic [1:0]  xfer_sz = '0;
    logic        is_read = 1'b0;
    logic        pstrobe = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [63:0] host_wdata = '0;
    logic        ack;
    logic [63:0] host_rdata;
    logic [63:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nba_beat_accum dut (
        .clk(clk), .rst_n(rst_n), .start(start), .port_sz(port_sz),
        .xfer_sz(xfer_sz), .is_read(is_read), .pstrobe(pstrobe),
        .mem_rdata(mem_rdata), .host_wdata(host_wdata),
        .ack(ack), .host_rdata(host_rdata), .mem_wdata(mem_wdata)
    );

    // {port, xfer, read, strobes needed}
    localparam int NV = 15;
    localparam logic [8:0] VEC [NV] = '{
        {2'd0, 2'd3, 1'b1, 4'd1}, {2'd0, 2'd0, 1'b1, 4'd1},
        {2'd1, 2'd3, 1'b1, 4'd2}, {2'd1, 2'd2, 1'b1, 4'd1},
        {2'd1, 2'd0, 1'b1, 4'd1}, {2'd2, 2'd3, 1'b1, 4'd4},
        {2'd2, 2'd2, 1'b1, 4'd2}, {2'd2, 2'd1, 1'b1, 4'd1},
        {2'd3, 2'd3, 1'b1, 4'd8}, {2'd3, 2'd2, 1'b1, 4'd4},
        {2'd3, 2'd1, 1'b1, 4'd2}, {2'd3, 2'd0, 1'b1, 4'd1},
        {2'd1, 2'd3, 1'b0, 4'd2}, {2'd3, 2'd3, 1'b0, 4'd8},
        {2'd2, 2'd2, 1'b0, 4'd2}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string port_tag(input logic [1:0] p);
        case (p)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic do_start(input logic [1:0] p, input logic [1:0] x, input logic rd, input logic stb);
        start = 1'b1; port_sz = p; xfer_sz = x; is_read = rd; pstrobe = stb;
        @(negedge clk);
        start = 1'b0; pstrobe = 1'b0;
    endtask

    // bytes of the read bus for strobe i of vector v: top lanes carry data
    function automatic logic [63:0] rd_pattern(input int v, input int i);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[63-8*j -: 8] = 8'((i << 4) | j) ^ 8'(v * 37);
        return r;
    endfunction

    task automatic run_beat(input int v, input logic [1:0] p, input logic rd, input int need, input string tag);
        int pb;
        logic [63:0] exp_r;
        logic [63:0] exp_w;
        pb = 8 >> p;
        exp_r = '0;
        host_wdata = 64'h0123_4567_89AB_CDEF ^ {8{8'(v)}};
        for (int i = 0; i < need; i++) begin
            mem_rdata = rd_pattern(v, i);
            pstrobe = 1'b1;
            #1;
            if (!rd) begin
                exp_w = '0;
                for (int j = 0; j < pb; j++) exp_w[63-8*j -: 8] = host_wdata[63-8*(i*pb+j) -: 8];
                check(mem_wdata == exp_w, "R8 write slice", mem_wdata, exp_w);
            end else begin
                for (int j = 0; j < pb; j++) exp_r[63-8*(i*pb+j) -: 8] = mem_rdata[63-8*j -: 8];
            end
            @(negedge clk);
            pstrobe = 1'b0;
            check(ack == (i == need-1), {port_tag(p), " R6 ack timing"}, 64'(ack), 64'(i == need-1));
            if (rd && i == need-1) check(host_rdata == exp_r, "R7 read pack", host_rdata, exp_r);
        end
        @(negedge clk);
        check(ack == 1'b0, {tag, " R6 single cycle"}, 64'(ack), 64'd0);
    endtask

    initial begin
        logic [63:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ack == 1'b0, "R1 ack reset", 64'(ack), 64'd0);
        check(host_rdata == '0, "R1 rdata reset", host_rdata, 64'd0);
        check(mem_wdata == '0, "R1 wdata reset", mem_wdata, 64'd0);
        @(negedge clk);
        pstrobe = 1'b1; mem_rdata = '1;
        @(negedge clk);
        pstrobe = 1'b0;
        check(ack == 1'b0, "R1 strobe before start", 64'(ack), 64'd0);
        check(host_rdata == '0, "R1 rdata untouched", host_rdata, 64'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_start(VEC[v][8:7], VEC[v][6:5], VEC[v][4], 1'b0);
            run_beat(v, VEC[v][8:7], VEC[v][4], int'(VEC[v][3:0]), port_tag(VEC[v][8:7]));
        end

        // R9: restart discards a partial beat
        do_start(2'd3, 2'd3, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            pstrobe = 1'b1; @(negedge clk); pstrobe = 1'b0;
        end
        check(ack == 1'b0, "R9 partial no ack", 64'(ack), 64'd0);
        do_start(2'd3, 2'd0, 1'b1, 1'b0);
        mem_rdata = 64'hA5FF_FFFF_FFFF_FFFF;
        pstrobe = 1'b1; @(negedge clk); pstrobe = 1'b0;
        check(ack == 1'b1, "R9 restart counts fresh", 64'(ack), 64'd1);
        check(host_rdata == 64'hA500_0000_0000_0000, "R7 byte beat zeroes rest", host_rdata, 64'hA500_0000_0000_0000);

        // R9: strobe together with start is not counted
        do_start(2'd2, 2'd2, 1'b1, 1'b1);
        pstrobe = 1'b1; @(negedge clk); pstrobe = 1'b0;
        check(ack == 1'b0, "R9 start-cycle strobe dropped", 64'(ack), 64'd0);
        pstrobe = 1'b1; @(negedge clk); pstrobe = 1'b0;
        check(ack == 1'b1, "R9 ack on second counted", 64'(ack), 64'd1);
        @(negedge clk);

        // R6: burst on a full-width port, one ack per cycle
        do_start(2'd0, 2'd3, 1'b1, 1'b0);
        pstrobe = 1'b1;
        for (int i = 0; i < 3; i++) begin
            mem_rdata = {8{8'(8'h10 + i)}};
            @(negedge clk);
            check(ack == 1'b1, "R6 burst ack", 64'(ack), 64'd1);
            check(host_rdata == {8{8'(8'h10 + i)}}, "R7 burst data", host_rdata, {8{8'(8'h10 + i)}});
        end
        pstrobe = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R6 burst end", 64'(ack), 64'd0);

        // R10: write beats leave the read word alone; R8 full-width write
        keep = host_rdata;
        do_start(2'd0, 2'd3, 1'b0, 1'b0);
        host_wdata = 64'hDEAD_BEEF_CAFE_F00D; mem_rdata = '0;
        #1;
        check(mem_wdata == 64'hDEAD_BEEF_CAFE_F00D, "R8 full port write", mem_wdata, 64'hDEAD_BEEF_CAFE_F00D);
        pstrobe = 1'b1; @(negedge clk); pstrobe = 1'b0;
        check(ack == 1'b1, "R2 write ack", 64'(ack), 64'd1);
        check(host_rdata == keep, "R10 rdata held", host_rdata, keep);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule